// File: doc/BRIEF.md
# Stepwise Modulo-N Adder with Scratch Uncompute

This block adds two residues `a` and `b` modulo a modulus `N` that is supplied at run time, using a single shared add/subtract unit driven over a fixed sequence of steps. The accumulator is one bit wider than the operands, so intermediate sums and differences never overflow, and its top bit acts as a sign.

The correction scheme first removes `N` from `a+b` and then adds it back only when that removal went negative. The decision is held in a temporary flag. A second subtract/compare/add sequence on `a` then returns that flag to zero. When the sequence finishes, the operand slot again holds `a`, the parking slot again holds `N`, and the flag and the captured carry vector are both zero.

A caller presents `a`, `b` and `N` with a one-cycle `start` while the block is idle. It then waits for the one-cycle `done` pulse. Results stay on the outputs until the next operation is accepted.

Top module: `modn_stepadd`

States, in order: `ST_IDLE` →(start) `ST_ADD_AB` → `ST_SWAP_IN` → `ST_SUB_N` → `ST_FLAG_SET` → `ST_MASK_N` → `ST_ADD_N` → `ST_UNMASK_N` → `ST_SWAP_OUT` → `ST_SUB_A` → `ST_FLAG_CLR` → `ST_ADD_A` → `ST_RETIRE` → `ST_DONE` → `ST_IDLE`. Every state other than `ST_IDLE` moves on unconditionally after one cycle.

## Requirements
- R1: For 2 ≤ N ≤ 2^W−1 and a, b < N, `sum_out` equals (a+b) mod N while `done` is high and afterwards until the next accepted start.
- R2: After completion, `a_hold` equals the `a` operand presented with the accepted start.
- R3: After completion, `mod_hold` equals the modulus presented with the accepted start.
- R4: A start accepted at clock edge k makes `busy` high from edge k through edge k+13, and makes `done` high for exactly the one cycle that follows edge k+12.
- R5: A `start` asserted while `busy` is high, including in the `done` cycle, is ignored, and the running operation's results are the ones delivered.
- R6: `scratch_err` is high only if the temporary flag or any captured carry bit is nonzero in the `done` cycle. On a correct run it stays low.
- R7: After reset, `busy`, `done` and `scratch_err` are low, and `sum_out`, `a_hold` and `mod_hold` are zero.
- R8: When a+b ≥ N the result is a+b−N, including a+b = N, which gives 0. When a+b < N the result is a+b.
- R9: The results are correct at the modulus limits N = 2 and N = 2^W−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| a_in | input | W | First residue, below the modulus |
| b_in | input | W | Second residue, below the modulus |
| mod_in | input | W | Modulus N, 2 or more |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| sum_out | output | W | Residue result (low W bits of the accumulator) |
| a_hold | output | W | Operand slot; holds a after completion |
| mod_hold | output | W | Parking slot; holds N after completion |
| scratch_err | output | 1 | Scratch state found nonzero at completion |

## Verification
Errors inside the sequence surface only at completion. A wrong flag polarity or a swapped slot leaves `sum_out` off by N, or leaves `a_hold` and `mod_hold` exchanged, in the `done` cycle 13 cycles after start. A flag that is not uncomputed raises `scratch_err` in that same cycle. A miscounted state chain moves the `done` pulse away from edge k+12, and a reference that counts cycles catches this on the first operation. Because the operands are chosen on both sides of a+b = N and at both modulus limits, each branch of the conditional add-back is exercised.

// File: rtl/modn_stepadd_pkg.sv
package modn_stepadd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADD_AB, ST_SWAP_IN, ST_SUB_N, ST_FLAG_SET,
        ST_MASK_N, ST_ADD_N, ST_UNMASK_N, ST_SWAP_OUT, ST_SUB_A,
        ST_FLAG_CLR, ST_ADD_A, ST_RETIRE, ST_DONE
    } step_e;

    typedef struct packed {
        logic load;     // capture operands
        logic pass;     // accumulator takes adder result
        logic sub;      // adder subtracts
        logic swap;     // exchange operand and parking slots
        logic flag_set; // flag ^= ~sign
        logic flag_clr; // flag ^= sign
        logic mask;     // if flag, slot ^= modulus
        logic busy;
        logic done;
    } ctl_t;

endpackage

// File: rtl/modn_addsub.sv
module modn_addsub #(
    parameter int W = 8
) (
    input  logic [W:0]   acc,
    input  logic [W-1:0] opd,
    input  logic         sub,
    output logic [W:0]   res,
    output logic [W:0]   carries
);
    logic [W:0]   y;
    logic [W+1:0] c;

    assign y    = sub ? ~{1'b0, opd} : {1'b0, opd};
    assign c[0] = sub;

    for (genvar i = 0; i <= W; i++) begin : g_bit
        assign res[i]   = acc[i] ^ y[i] ^ c[i];
        assign c[i+1]   = (acc[i] & y[i]) | (acc[i] & c[i]) | (y[i] & c[i]);
    end

    assign carries = c[W+1:1];
endmodule

// File: rtl/modn_seq_ctrl.sv
module modn_seq_ctrl
    import modn_stepadd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output ctl_t ctl
);
    step_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = start ? ST_ADD_AB : ST_IDLE;
            ST_ADD_AB:   state_d = ST_SWAP_IN;
            ST_SWAP_IN:  state_d = ST_SUB_N;
            ST_SUB_N:    state_d = ST_FLAG_SET;
            ST_FLAG_SET: state_d = ST_MASK_N;
            ST_MASK_N:   state_d = ST_ADD_N;
            ST_ADD_N:    state_d = ST_UNMASK_N;
            ST_UNMASK_N: state_d = ST_SWAP_OUT;
            ST_SWAP_OUT: state_d = ST_SUB_A;
            ST_SUB_A:    state_d = ST_FLAG_CLR;
            ST_FLAG_CLR: state_d = ST_ADD_A;
            ST_ADD_A:    state_d = ST_RETIRE;
            ST_RETIRE:   state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl      = '0;
        ctl.busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:     ctl.load = start;
            ST_ADD_AB:   ctl.pass = 1'b1;
            ST_SWAP_IN:  ctl.swap = 1'b1;
            ST_SUB_N:    begin ctl.pass = 1'b1; ctl.sub = 1'b1; end
            ST_FLAG_SET: ctl.flag_set = 1'b1;
            ST_MASK_N:   ctl.mask = 1'b1;
            ST_ADD_N:    ctl.pass = 1'b1;
            ST_UNMASK_N: ctl.mask = 1'b1;
            ST_SWAP_OUT: ctl.swap = 1'b1;
            ST_SUB_A:    begin ctl.pass = 1'b1; ctl.sub = 1'b1; end
            ST_FLAG_CLR: ctl.flag_clr = 1'b1;
            ST_ADD_A:    ctl.pass = 1'b1;
            ST_RETIRE:   ;
            ST_DONE:     ctl.done = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/modn_stepadd.sv
module modn_stepadd
    import modn_stepadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] mod_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] sum_out,
    output logic [W-1:0] a_hold,
    output logic [W-1:0] mod_hold,
    output logic         scratch_err
);
    localparam int AW = W + 1;

    ctl_t          ctl;
    logic [AW-1:0] acc_q, acc_d, carry_d, carry_q;
    logic [W-1:0]  slot_q, park_q, modc_q;
    logic          flag_q;
    logic          sign;

    modn_seq_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ctl   (ctl)
    );

    modn_addsub #(.W(W)) u_alu (
        .acc     (acc_q),
        .opd     (slot_q),
        .sub     (ctl.sub),
        .res     (acc_d),
        .carries (carry_d)
    );

    assign sign = acc_q[AW-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= '0;
            slot_q  <= '0;
            park_q  <= '0;
            modc_q  <= '0;
            flag_q  <= 1'b0;
        end else begin
            carry_q <= ctl.pass ? carry_d : '0;
            if (ctl.load) begin
                acc_q  <= {1'b0, b_in};
                slot_q <= a_in;
                park_q <= mod_in;
                modc_q <= mod_in;
                flag_q <= 1'b0;
            end
            if (ctl.pass)     acc_q  <= acc_d;
            if (ctl.swap) begin
                slot_q <= park_q;
                park_q <= slot_q;
            end
            if (ctl.flag_set) flag_q <= flag_q ^ ~sign;
            if (ctl.flag_clr) flag_q <= flag_q ^ sign;
            if (ctl.mask && flag_q) slot_q <= slot_q ^ modc_q;
        end
    end

    assign busy        = ctl.busy;
    assign done        = ctl.done;
    assign sum_out     = acc_q[W-1:0];
    assign a_hold      = slot_q;
    assign mod_hold    = park_q;
    assign scratch_err = ctl.done & (flag_q | (|carry_q));
endmodule

// File: rtl/modn_stepadd_chk.sv
module modn_stepadd_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] sum_out,
    input logic [W-1:0] mod_hold,
    input logic         scratch_err
);
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R5
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R6
    scratch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !scratch_err);
    // R1
    residue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sum_out < mod_hold));
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);
    // R5
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(sum_out));
endmodule

bind modn_stepadd modn_stepadd_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .sum_out     (sum_out),
    .mod_hold    (mod_hold),
    .scratch_err (scratch_err)
);

// File: tb/modn_stepadd_tb.sv
module modn_stepadd_tb_top;
    localparam int W      = 8;
    localparam int CLK_NS = 10;
    localparam int LAT    = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, mod_in = '0;
    logic         busy, done, scratch_err;
    logic [W-1:0] sum_out, a_hold, mod_hold;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    int cnt = 0;
    int exp_sum = 0, exp_a = 0, exp_n = 0;

    always #(CLK_NS/2) clk = ~clk;

    modn_stepadd #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_in(a_in), .b_in(b_in), .mod_in(mod_in),
        .busy(busy), .done(done), .sum_out(sum_out),
        .a_hold(a_hold), .mod_hold(mod_hold), .scratch_err(scratch_err)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; exp_sum = 0; exp_a = 0; exp_n = 0;
        end else if (cnt > 0) begin
            cnt = cnt - 1;              // R5: start ignored while busy
        end else if (start) begin
            cnt     = LAT;
            exp_sum = (int'(a_in) + int'(b_in)) % int'(mod_in);
            exp_a   = int'(a_in);
            exp_n   = int'(mod_in);
        end
    end

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cmp("R4 busy", int'(busy), int'(cnt > 0));
            cmp("R4 done", int'(done), int'(cnt == 1));
            cmp("R6 scratch_err", int'(scratch_err), 0);
            if (cnt <= 1) begin
                cmp("R1/R8/R9 sum_out", int'(sum_out), exp_sum);
                cmp("R2 a_hold", int'(a_hold), exp_a);
                cmp("R3 mod_hold", int'(mod_hold), exp_n);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic op(input int a, input int b, input int n);
        @(negedge clk);
        a_in = W'(a); b_in = W'(b); mod_in = W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        cmp("R7 busy", int'(busy), 0);
        cmp("R7 done", int'(done), 0);
        cmp("R7 sum_out", int'(sum_out), 0);
        cmp("R7 a_hold", int'(a_hold), 0);
        cmp("R7 mod_hold", int'(mod_hold), 0);
        rst_n = 1'b1;
        @(negedge clk);
        op(3, 4, 11);       // R8 no wrap
        op(7, 9, 11);       // R8 wrap
        op(5, 6, 11);       // R8 exact N -> 0
        op(1, 1, 2);        // R9 N=2
        op(1, 0, 2);        // R9
        op(254, 254, 255);  // R9 max modulus
        op(0, 0, 255);      // R9
        op(128, 127, 255);  // R8 exact at max
        // R5: start re-asserted while busy with other operands
        @(negedge clk);
        a_in = 8'd20; b_in = 8'd30; mod_in = 8'd37; start = 1'b1;
        @(negedge clk);
        a_in = 8'd1; b_in = 8'd2; mod_in = 8'd5;
        repeat (5) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        // R5: start held through the done cycle
        @(negedge clk);
        a_in = 8'd9; b_in = 8'd8; mod_in = 8'd10; start = 1'b1;
        repeat (LAT + 3) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        // random operands, R1
        for (int i = 0; i < 300; i++) begin
            int n, a, b;
            n = 2 + int'($urandom % 254);
            a = int'($urandom % n);
            b = int'($urandom % n);
            op(a, b, n);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule